// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Overflow Flag

This block is a 32-bit arithmetic unit. It adds and subtracts with saturation in both signed and unsigned form. It can also double a signed value with saturation, and it can clamp a value to a chosen bit width. The width clamp works on the whole word or on each 16-bit half independently. There is also a plain add that wraps but still reports signed overflow. Each operation is issued for one cycle with `valid_i` and the chosen opcode, and its result appears on `result_o` on the following cycle.

Every clamping event, and every signed overflow of the plain add, sets one shared sticky flag. Arithmetic never clears this flag. Only a pulse on `flag_clear_i` or a reset clears it, so software can run a batch of operations and then test once whether any of them lost precision.

Top module: `sat_alu`

## Requirements
- R1: Opcode 0 (plain add) returns the wrapped sum a+b and sets the sticky flag when a and b have the same sign and the sign of the sum differs from it.
- R2: Opcode 1 (signed saturating add) returns a+b. On signed overflow it returns 0x7FFFFFFF if a is non-negative or 0x80000000 if a is negative, and it sets the flag.
- R3: Opcode 2 (signed saturating subtract) returns a-b. When a and b differ in sign and the sign of the result differs from a, it returns 0x7FFFFFFF if a is non-negative or 0x80000000 if a is negative, and it sets the flag.
- R4: Opcode 3 (unsigned saturating add) returns 0xFFFFFFFF and sets the flag when the 32-bit sum wraps. Otherwise it returns the sum.
- R5: Opcode 4 (unsigned saturating subtract) returns 0 and sets the flag when b is greater than a. Otherwise it returns a-b.
- R6: Opcode 5 (saturating double) returns 0x7FFFFFFF for a signed a of at least 0x40000000 and 0x80000000 for a signed a of at most 0xC0000000, setting the flag in both cases. Otherwise it returns a shifted left by one.
- R7: Opcode 6 (signed width clamp, n = width_i) returns 2^n-1 when a>>>n is greater than 0, and the complement of 2^n-1 when a>>>n is less than -1, setting the flag in both cases. Otherwise a passes through unchanged.
- R8: Opcode 7 (unsigned width clamp) returns 0 for a negative a and 2^n-1 for an a above 2^n-1, setting the flag in both cases. Otherwise a passes through unchanged.
- R9: Opcodes 8 and 9 apply the signed and unsigned width clamps to each sign-extended 16-bit half of a separately. The low 16 bits of each lane result are packed into the same half of the result, and a clamp in either lane sets the flag.
- R10: The sticky flag is set by any saturating event on an issued operation and holds otherwise. A `flag_clear_i` pulse clears it. A set in the same cycle as a clear wins.
- R11: `result_o` updates on the clock edge at which `valid_i` is high and holds while `valid_i` is low. Reset drives `result_o` and the flag to 0.
- R12: Opcodes 10 to 15 produce a result of 0 and never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe for the operation on op_i |
| op_i | input | 4 | Operation select |
| a_i | input | 32 | Operand a |
| b_i | input | 32 | Operand b |
| width_i | input | 5 | Clamp width n for opcodes 6 to 9 |
| flag_clear_i | input | 1 | Clears the sticky flag |
| result_o | output | 32 | Registered result |
| sticky_o | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that opcode, operands and width are stable and meaningful only in a cycle in which `valid_i` is high, and they judge each result against the inputs captured in that cycle. They also assume that `flag_clear_i` may arrive in any cycle, including together with an issue. The stimulus changes inputs only on the falling edge and issues one operation at a time with `valid_i` high for a single cycle. It pulses the clear before each vector so that the flag reflects that vector alone, except in the one case that deliberately overlaps clear and issue.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SADD  = 4'd1,
    OP_SSUB  = 4'd2,
    OP_UADD  = 4'd3,
    OP_USUB  = 4'd4,
    OP_SDBL  = 4'd5,
    OP_SSAT  = 4'd6,
    OP_USAT  = 4'd7,
    OP_SSAT2 = 4'd8,
    OP_USAT2 = 4'd9
  } sat_op_e;

  localparam int unsigned NUM_OPS = 10;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
  import sat_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0]   sum_ext;
  logic [W-1:0] sum, diff, sclamp;
  logic         s_add_ovf, s_sub_ovf, u_add_ovf, u_sub_ovf;
  logic         dbl_hi, dbl_lo;

  assign sum_ext   = {1'b0, a_i} + {1'b0, b_i};
  assign sum       = sum_ext[W-1:0];
  assign diff      = a_i - b_i;
  assign s_add_ovf = ~(a_i[W-1] ^ b_i[W-1]) & (sum[W-1] ^ a_i[W-1]);
  assign s_sub_ovf = (a_i[W-1] ^ b_i[W-1]) & (diff[W-1] ^ a_i[W-1]);
  assign u_add_ovf = sum_ext[W];
  assign u_sub_ovf = b_i > a_i;
  assign sclamp    = a_i[W-1] ? SMIN : SMAX;
  // doubling bounds: a >= 2^(W-2), a <= -2^(W-2)
  assign dbl_hi    = ~a_i[W-1] & a_i[W-2];
  assign dbl_lo    = a_i[W-1] & (~a_i[W-2] | ~(|a_i[W-3:0]));

  always_comb begin
    res_o = '0;
    sat_o = 1'b0;
    case (op_i)
      OP_ADD: begin
        res_o = sum;
        sat_o = s_add_ovf;
      end
      OP_SADD: begin
        res_o = s_add_ovf ? sclamp : sum;
        sat_o = s_add_ovf;
      end
      OP_SSUB: begin
        res_o = s_sub_ovf ? sclamp : diff;
        sat_o = s_sub_ovf;
      end
      OP_UADD: begin
        res_o = u_add_ovf ? '1 : sum;
        sat_o = u_add_ovf;
      end
      OP_USUB: begin
        res_o = u_sub_ovf ? '0 : diff;
        sat_o = u_sub_ovf;
      end
      OP_SDBL: begin
        res_o = dbl_hi ? SMAX : (dbl_lo ? SMIN : {a_i[W-2:0], 1'b0});
        sat_o = dbl_hi | dbl_lo;
      end
      default: begin
        res_o = '0;
        sat_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int unsigned W     = 32,
  parameter int unsigned OUT_W = 32,
  localparam int unsigned NW   = $clog2(W)
) (
  input  logic [W-1:0]     val_i,
  input  logic [NW-1:0]    n_i,
  input  logic             signed_i,
  output logic [OUT_W-1:0] res_o,
  output logic             sat_o
);
  logic signed [W-1:0] top;
  logic [OUT_W-1:0]    lim;
  logic                s_pos, s_neg, u_neg, u_over;

  assign top    = $signed(val_i) >>> n_i;
  assign s_pos  = ~top[W-1] & (|top);
  assign s_neg  = top[W-1] & ~(&top);
  assign u_neg  = val_i[W-1];
  assign u_over = ~val_i[W-1] & (|(val_i & ({W{1'b1}} << n_i)));
  assign lim    = ~({OUT_W{1'b1}} << n_i);

  always_comb begin
    res_o = val_i[OUT_W-1:0];
    sat_o = 1'b0;
    if (signed_i) begin
      if (s_pos) begin
        res_o = lim;
        sat_o = 1'b1;
      end else if (s_neg) begin
        res_o = ~lim;
        sat_o = 1'b1;
      end
    end else begin
      if (u_neg) begin
        res_o = '0;
        sat_o = 1'b1;
      end else if (u_over) begin
        res_o = lim;
        sat_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  AST_STICKY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o); // R10
  AST_STICKY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o); // R10
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(flag_o)); // R10
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned HW    = DATA_W / 2,
  localparam int unsigned NW    = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [NW-1:0]     width_i,
  input  logic              flag_clear_i,
  output logic [DATA_W-1:0] result_o,
  output logic              sticky_o
);
  logic [DATA_W-1:0] as_res, word_res, nxt_res;
  logic              as_sat, word_sat, nxt_sat, clamp_signed;
  logic [HW-1:0]     lane_res [2];
  logic [1:0]        lane_sat;

  assign clamp_signed = (op_i == OP_SSAT) || (op_i == OP_SSAT2);

  sat_addsub #(.W(DATA_W)) u_addsub (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (op_i),
    .res_o(as_res),
    .sat_o(as_sat)
  );

  sat_clamp #(.W(DATA_W), .OUT_W(DATA_W)) u_word_clamp (
    .val_i   (a_i),
    .n_i     (width_i),
    .signed_i(clamp_signed),
    .res_o   (word_res),
    .sat_o   (word_sat)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [DATA_W-1:0] lane_val;
    assign lane_val = {{(DATA_W-HW){a_i[g*HW+HW-1]}}, a_i[g*HW +: HW]};
    sat_clamp #(.W(DATA_W), .OUT_W(HW)) u_lane_clamp (
      .val_i   (lane_val),
      .n_i     (width_i),
      .signed_i(clamp_signed),
      .res_o   (lane_res[g]),
      .sat_o   (lane_sat[g])
    );
  end

  always_comb begin
    nxt_res = '0;
    nxt_sat = 1'b0;
    case (op_i)
      OP_ADD, OP_SADD, OP_SSUB, OP_UADD, OP_USUB, OP_SDBL: begin
        nxt_res = as_res;
        nxt_sat = as_sat;
      end
      OP_SSAT, OP_USAT: begin
        nxt_res = word_res;
        nxt_sat = word_sat;
      end
      OP_SSAT2, OP_USAT2: begin
        nxt_res = {lane_res[1], lane_res[0]};
        nxt_sat = |lane_sat;
      end
      default: begin
        nxt_res = '0;
        nxt_sat = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      result_o <= '0;
    else if (valid_i) result_o <= nxt_res;
  end

  sat_sticky u_sticky (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (valid_i & nxt_sat),
    .clr_i (flag_clear_i),
    .flag_o(sticky_o)
  );

  logic [DATA_W-1:0] umask;
  assign umask = {DATA_W{1'b1}} << width_i;

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R11
  AST_SADD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SADD && as_sat) |=>
      (result_o == {1'b0, {(DATA_W-1){1'b1}}} || result_o == {1'b1, {(DATA_W-1){1'b0}}})); // R2
  AST_USUB_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_USUB && b_i > a_i) |=> result_o == '0); // R5
  AST_USAT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_USAT) |=> (result_o & $past(umask)) == '0); // R8
  AST_UNDEF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= 4'(NUM_OPS)) |=> (result_o == '0 && !$rose(sticky_o))); // R12
endmodule

// File: tb/sat_alu_test.sv
`timescale 1ns/1ps
module sat_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic [4:0]  width = '0;
  logic        clr = 1'b0;
  logic [31:0] result;
  logic        sticky;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sat_alu uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .a_i(a), .b_i(b),
    .width_i(width), .flag_clear_i(clr), .result_o(result), .sticky_o(sticky)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // clear, issue one op, sample result and flag one cycle later
  task automatic run_vec(input string req, input logic [3:0] o, input logic [31:0] va,
                         input logic [31:0] vb, input logic [4:0] w,
                         input logic [31:0] exp, input logic exp_flag);
    clear_flag();
    op = o; a = va; b = vb; width = w; valid = 1'b1;
    @(negedge clk); valid = 1'b0;
    check(req, "result", result, exp);
    check(req, "sticky", {31'b0, sticky}, {31'b0, exp_flag});
  endtask

  task automatic test_reset();
    check("R11", "reset result", result, 32'h0);
    check("R11", "reset sticky", {31'b0, sticky}, 32'h0);
  endtask

  task automatic test_plain_add();
    run_vec("R1", 4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 32'h80000000, 1'b1);
    run_vec("R1", 4'd0, 32'd5, 32'd7, 5'd0, 32'd12, 1'b0);
  endtask

  task automatic test_sadd();
    run_vec("R2", 4'd1, 32'h7FFFFFF0, 32'h20, 5'd0, 32'h7FFFFFFF, 1'b1);
    run_vec("R2", 4'd1, 32'h80000000, 32'hFFFFFFFF, 5'd0, 32'h80000000, 1'b1);
    run_vec("R2", 4'd1, 32'd100, 32'hFFFFFFFF, 5'd0, 32'd99, 1'b0);
  endtask

  task automatic test_ssub();
    run_vec("R3", 4'd2, 32'h80000000, 32'h1, 5'd0, 32'h80000000, 1'b1);
    run_vec("R3", 4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 32'h7FFFFFFF, 1'b1);
    run_vec("R3", 4'd2, 32'd10, 32'd20, 5'd0, 32'hFFFFFFF6, 1'b0);
  endtask

  task automatic test_unsigned();
    run_vec("R4", 4'd3, 32'hFFFFFFF0, 32'h20, 5'd0, 32'hFFFFFFFF, 1'b1);
    run_vec("R4", 4'd3, 32'd1, 32'd2, 5'd0, 32'd3, 1'b0);
    run_vec("R5", 4'd4, 32'd5, 32'd9, 5'd0, 32'd0, 1'b1);
    run_vec("R5", 4'd4, 32'd9, 32'd5, 5'd0, 32'd4, 1'b0);
  endtask

  task automatic test_double();
    run_vec("R6", 4'd5, 32'h40000000, 32'h0, 5'd0, 32'h7FFFFFFF, 1'b1);
    run_vec("R6", 4'd5, 32'hC0000000, 32'h0, 5'd0, 32'h80000000, 1'b1);
    run_vec("R6", 4'd5, 32'hC0000001, 32'h0, 5'd0, 32'h80000002, 1'b0);
    run_vec("R6", 4'd5, 32'h3FFFFFFF, 32'h0, 5'd0, 32'h7FFFFFFE, 1'b0);
  endtask

  task automatic test_word_clamp();
    run_vec("R7", 4'd6, 32'd200, 32'h0, 5'd7, 32'd127, 1'b1);
    run_vec("R7", 4'd6, 32'hFFFFFED4, 32'h0, 5'd7, 32'hFFFFFF80, 1'b1);
    run_vec("R7", 4'd6, 32'hFFFFFF80, 32'h0, 5'd7, 32'hFFFFFF80, 1'b0);
    run_vec("R7", 4'd6, 32'd127, 32'h0, 5'd7, 32'd127, 1'b0);
    run_vec("R8", 4'd7, 32'd300, 32'h0, 5'd8, 32'd255, 1'b1);
    run_vec("R8", 4'd7, 32'hFFFFFFFB, 32'h0, 5'd8, 32'd0, 1'b1);
    run_vec("R8", 4'd7, 32'd255, 32'h0, 5'd8, 32'd255, 1'b0);
    run_vec("R8", 4'd7, 32'd1, 32'h0, 5'd0, 32'd0, 1'b1);
  endtask

  task automatic test_dual();
    run_vec("R9", 4'd8, 32'h0100FF00, 32'h0, 5'd7, 32'h007FFF80, 1'b1);
    run_vec("R9", 4'd8, 32'h7FFF8000, 32'h0, 5'd15, 32'h7FFF8000, 1'b0);
    run_vec("R9", 4'd9, 32'hFFFB0050, 32'h0, 5'd8, 32'h00000050, 1'b1);
    run_vec("R9", 4'd9, 32'h00100020, 32'h0, 5'd8, 32'h00100020, 1'b0);
  endtask

  task automatic test_sticky();
    run_vec("R10", 4'd3, 32'hFFFFFFFF, 32'h1, 5'd0, 32'hFFFFFFFF, 1'b1);
    repeat (3) @(negedge clk);
    check("R10", "hold idle", {31'b0, sticky}, 32'h1);
    op = 4'd3; a = 32'd1; b = 32'd1; valid = 1'b1;
    @(negedge clk); valid = 1'b0;
    check("R10", "hold after clean op", {31'b0, sticky}, 32'h1);
    clear_flag();
    check("R10", "cleared", {31'b0, sticky}, 32'h0);
    op = 4'd1; a = 32'h7FFFFFFF; b = 32'h7FFFFFFF; valid = 1'b1; clr = 1'b1;
    @(negedge clk); valid = 1'b0; clr = 1'b0;
    check("R10", "set beats clear", {31'b0, sticky}, 32'h1);
  endtask

  task automatic test_hold();
    run_vec("R11", 4'd3, 32'd40, 32'd2, 5'd0, 32'd42, 1'b0);
    a = 32'h12345678; b = 32'h1; op = 4'd0;
    repeat (3) @(negedge clk);
    check("R11", "hold while idle", result, 32'd42);
  endtask

  task automatic test_undef();
    run_vec("R12", 4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd31, 32'h0, 1'b0);
    run_vec("R12", 4'd10, 32'h80000000, 32'h7FFFFFFF, 5'd0, 32'h0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_plain_add();
    test_sadd();
    test_ssub();
    test_unsigned();
    test_double();
    test_word_clamp();
    test_dual();
    test_sticky();
    test_hold();
    test_undef();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule